// File: doc/BRIEF.md
# SMBus Word-Register Slave

This block is a bus slave for the two-wire SMBus word protocols. It serves four 16-bit command registers through the write-word and read-word transfers. SCL and SDA arrive as raw pin levels and are sampled on a fast system clock. Each line passes through a two-flop synchronizer and a stability filter. A START (SDA falling while SCL is high) and a STOP (SDA rising while SCL is high) are recognised from the filtered levels. The block returns one open-drain enable: when `sda_oe` is high, the pad pulls SDA low.

A write carries the address byte with write direction, then a command byte, then the low data byte, then the high data byte. The slave acknowledges every byte, but takes no action until the STOP that closes the transfer. At that STOP the host side receives a one-cycle strobe together with the command code and the assembled word. A read also sends the address and command bytes. The master then issues a repeated START and sends the address byte with read direction. The slave acknowledges it, samples the host-supplied value of the selected register, and returns the low byte followed by the high byte. Each byte goes out MSB first.

The FSM has these states. IDLE waits for a START. ADDR receives the address byte, and ADDR_ACK acknowledges it. CMD receives the command, and CMD_ACK acknowledges it. DLO and DLO_ACK handle the low write byte, and DHI and DHI_ACK handle the high write byte. HOLD waits for the committing STOP. TX shifts a read byte out, and TX_ACK samples the master's reply. SKIP waits, with SDA released, for the next START or STOP. Transitions: a STOP in any state goes to IDLE, and out of HOLD it also commits the write. A START in any state goes to ADDR. Each receive state moves to its ACK state at the falling SCL edge after the eighth bit, or to SKIP on a NACK decision. Each ACK state moves on at the falling edge that ends the ninth clock. TX goes to TX_ACK after eight bits. TX_ACK goes back to TX for the high byte after a master ACK on the low byte, and to SKIP otherwise.

Top module: `smbw_word_slave`

## Requirements
- R1: A START seen in any state, including partway through a byte, restarts address reception. A STOP seen in any state returns the slave to idle and discards the partial transfer.
- R2: Address 7'b0001001 is acknowledged with SDA pulled low. Any other address gets no acknowledge, and SDA stays released until the next START or STOP.
- R3: Command bytes 0x14, 0x15, 0x3D and 0x3E are acknowledged. Any other command is not acknowledged, the data bytes that follow are not acknowledged either, and no write strobe results.
- R4: In a write, both data bytes are acknowledged. The first data byte is bits 7..0 of the word and the second is bits 15..8.
- R5: A STOP after the high-byte acknowledge gives exactly one `wr_stb` pulse with `wr_cmd` and `wr_data`. If a START arrives in place of that STOP, no strobe is produced.
- R6: A read returns the selected register with the low byte first and MSB first within each byte. The selection is 0x14→`rd_cur_i`, 0x15→`rd_vlt_i`, 0x3D→`rd_rln_i`, 0x3E→`rd_vin_i`.
- R7: The read word is sampled when the address byte with read direction is acknowledged. Later changes on the register inputs do not alter the bytes sent.
- R8: An address byte with read direction is not acknowledged unless a supported command was received earlier in the same transfer.
- R9: A master NACK after the low read byte ends transmission, and the slave keeps SDA released until the next START or STOP.
- R10: `sda_oe` changes only while SCL is low.
- R11: Out of reset, `sda_oe` and `wr_stb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, far faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| sda_oe | output | 1 | High pulls SDA low |
| wr_stb | output | 1 | One-cycle commit strobe for a written word |
| wr_cmd | output | 8 | Command code of the committed write |
| wr_data | output | 16 | Committed word |
| rd_cur_i | input | 16 | Read value for command 0x14 |
| rd_vlt_i | input | 16 | Read value for command 0x15 |
| rd_rln_i | input | 16 | Read value for command 0x3D |
| rd_vin_i | input | 16 | Read value for command 0x3E |

## Verification
The bench runs the protocol with a bus-master model, using random words and a random choice among the four commands for both writes and reads. This separates byte-order and register-selection faults from shift-direction faults. Directed cases then target the decision points:
- a wrong address, which exercises the address comparison;
- an unsupported command, which exercises the command decoder;
- a START in place of the committing STOP, which exercises commit gating;
- a STOP partway through the address byte and a START partway through a data byte, which exercise resynchronisation;
- a read with no prior command, which exercises the read-direction guard;
- register inputs changed after the read acknowledge, which exercises the capture point;
- a master NACK on the low byte, which exercises release of SDA.

// File: rtl/smbw_pkg.sv
package smbw_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] CMD_CHG_CUR = 8'h14;
    localparam logic [BYTE_W-1:0] CMD_CHG_VLT = 8'h15;
    localparam logic [BYTE_W-1:0] CMD_RELEARN = 8'h3D;
    localparam logic [BYTE_W-1:0] CMD_IN_VLT  = 8'h3E;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_DLO,
        ST_DLO_ACK,
        ST_DHI,
        ST_DHI_ACK,
        ST_HOLD,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } smbw_state_e;

endpackage

// File: rtl/smbw_deglitch.sv
module smbw_deglitch #(
    parameter int STABLE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(STABLE + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // Two-flop synchronizer, then accept a new level only after it has held
    // for STABLE consecutive clocks.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            filt_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] != filt_o) begin
                if (cnt_q == CW'(STABLE - 1)) begin
                    filt_o <= sync_q[1];
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end
endmodule

// File: rtl/smbw_bus_events.sv
module smbw_bus_events #(
    parameter int STABLE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] filt;
    logic             scl_p;
    logic             sda_p;

    assign raw = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            smbw_deglitch #(.STABLE(STABLE)) u_flt (
                .clk    (clk),
                .rst_n  (rst_n),
                .raw_i  (raw[g]),
                .filt_o (filt[g])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= filt[0];
            sda_p <= filt[1];
        end
    end

    assign scl_lvl_o = filt[0];
    assign sda_lvl_o = filt[1];
    assign rise_o    =  filt[0] & ~scl_p;
    assign fall_o    = ~filt[0] &  scl_p;
    assign start_o   =  filt[0] &  scl_p &  sda_p & ~filt[1];
    assign stop_o    =  filt[0] &  scl_p & ~sda_p &  filt[1];

    // R1
    event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, stop_o, rise_o, fall_o}));
endmodule

// File: rtl/smbw_cmd_sel.sv
module smbw_cmd_sel
    import smbw_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd_i,
    input  logic [WORD_W-1:0] cur_i,
    input  logic [WORD_W-1:0] vlt_i,
    input  logic [WORD_W-1:0] rln_i,
    input  logic [WORD_W-1:0] vin_i,
    output logic              hit_o,
    output logic [WORD_W-1:0] val_o
);
    always_comb begin
        hit_o = 1'b1;
        unique case (cmd_i)
            CMD_CHG_CUR: val_o = cur_i;
            CMD_CHG_VLT: val_o = vlt_i;
            CMD_RELEARN: val_o = rln_i;
            CMD_IN_VLT:  val_o = vin_i;
            default: begin
                hit_o = 1'b0;
                val_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/smbw_word_slave.sv
module smbw_word_slave
    import smbw_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = 7'b0001001,
    parameter int         FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_cmd,
    output logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] rd_cur_i,
    input  logic [WORD_W-1:0] rd_vlt_i,
    input  logic [WORD_W-1:0] rd_rln_i,
    input  logic [WORD_W-1:0] rd_vin_i
);
    localparam int                BC_W     = $clog2(BYTE_W + 1);
    localparam logic [BC_W-1:0]   BYTE_END = BC_W'(BYTE_W);

    smbw_state_e       state, nxt;
    logic              scl_lvl, sda_lvl, start_ev, stop_ev, rise_ev, fall_ev;
    logic [BC_W-1:0]   bitcnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh, cmd_q, lo_q, sel_cmd;
    logic [WORD_W-1:0] rd_hold, sel_val, word_q;
    logic              cmd_valid, cmd_hit, tx_hi, m_ack, byte_end, addr_ok;

    smbw_bus_events #(.STABLE(FILT_LEN)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl_o (scl_lvl),
        .sda_lvl_o (sda_lvl),
        .start_o   (start_ev),
        .stop_o    (stop_ev),
        .rise_o    (rise_ev),
        .fall_o    (fall_ev)
    );

    // Decode the incoming byte while in CMD, otherwise the latched command.
    assign sel_cmd = (state == ST_CMD) ? rx_sh : cmd_q;

    smbw_cmd_sel u_sel (
        .cmd_i (sel_cmd),
        .cur_i (rd_cur_i),
        .vlt_i (rd_vlt_i),
        .rln_i (rd_rln_i),
        .vin_i (rd_vin_i),
        .hit_o (cmd_hit),
        .val_o (sel_val)
    );

    assign byte_end = (bitcnt == BYTE_END);
    assign addr_ok  = (rx_sh[7:1] == SLV_ADDR) && (!rx_sh[0] || cmd_valid);

    // Next-state logic
    always_comb begin
        nxt = state;
        if (stop_ev) begin
            nxt = ST_IDLE;
        end else if (start_ev) begin
            nxt = ST_ADDR;
        end else if (fall_ev) begin
            unique case (state)
                ST_ADDR:     if (byte_end) nxt = addr_ok ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: nxt = rx_sh[0] ? ST_TX : ST_CMD;
                ST_CMD:      if (byte_end) nxt = cmd_hit ? ST_CMD_ACK : ST_SKIP;
                ST_CMD_ACK:  nxt = ST_DLO;
                ST_DLO:      if (byte_end) nxt = ST_DLO_ACK;
                ST_DLO_ACK:  nxt = ST_DHI;
                ST_DHI:      if (byte_end) nxt = ST_DHI_ACK;
                ST_DHI_ACK:  nxt = ST_HOLD;
                ST_TX:       if (byte_end) nxt = ST_TX_ACK;
                ST_TX_ACK:   nxt = (!tx_hi && m_ack) ? ST_TX : ST_SKIP;
                default:     nxt = state;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt    <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            cmd_q     <= '0;
            lo_q      <= '0;
            word_q    <= '0;
            rd_hold   <= '0;
            cmd_valid <= 1'b0;
            tx_hi     <= 1'b0;
            m_ack     <= 1'b0;
            sda_oe    <= 1'b0;
            wr_stb    <= 1'b0;
            wr_cmd    <= '0;
            wr_data   <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (stop_ev || start_ev) begin
                bitcnt <= '0;
                sda_oe <= 1'b0;
                if (stop_ev) begin
                    cmd_valid <= 1'b0;
                    if (state == ST_HOLD) begin
                        wr_stb  <= 1'b1;
                        wr_cmd  <= cmd_q;
                        wr_data <= word_q;
                    end
                end
            end else if (rise_ev) begin
                unique case (state)
                    ST_ADDR, ST_CMD, ST_DLO, ST_DHI: begin
                        if (!byte_end) begin
                            rx_sh  <= {rx_sh[BYTE_W-2:0], sda_lvl};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_TX:     if (!byte_end) bitcnt <= bitcnt + 1'b1;
                    ST_TX_ACK: m_ack <= ~sda_lvl;
                    default: ;
                endcase
            end else if (fall_ev) begin
                if (nxt != state) bitcnt <= '0;
                unique case (state)
                    ST_ADDR: begin
                        if (byte_end && addr_ok) begin
                            sda_oe <= 1'b1;
                            if (rx_sh[0]) rd_hold   <= sel_val;
                            else          cmd_valid <= 1'b0;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (rx_sh[0]) begin
                            tx_sh  <= rd_hold[BYTE_W-1:0];
                            sda_oe <= ~rd_hold[BYTE_W-1];
                            tx_hi  <= 1'b0;
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_CMD: begin
                        if (byte_end && cmd_hit) begin
                            sda_oe    <= 1'b1;
                            cmd_q     <= rx_sh;
                            cmd_valid <= 1'b1;
                        end
                    end
                    ST_DLO: begin
                        if (byte_end) begin
                            sda_oe <= 1'b1;
                            lo_q   <= rx_sh;
                        end
                    end
                    ST_DHI: begin
                        if (byte_end) begin
                            sda_oe <= 1'b1;
                            word_q <= {rx_sh, lo_q};
                        end
                    end
                    ST_CMD_ACK, ST_DLO_ACK, ST_DHI_ACK: sda_oe <= 1'b0;
                    ST_TX: begin
                        if (byte_end) begin
                            sda_oe <= 1'b0;
                        end else if (bitcnt != '0) begin
                            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~tx_sh[BYTE_W-2];
                        end
                    end
                    ST_TX_ACK: begin
                        if (!tx_hi && m_ack) begin
                            tx_sh  <= rd_hold[WORD_W-1:BYTE_W];
                            sda_oe <= ~rd_hold[WORD_W-1];
                            tx_hi  <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10
    sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_oe));

    // R4
    rx_ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK || state == ST_CMD_ACK ||
         state == ST_DLO_ACK  || state == ST_DHI_ACK) |-> sda_oe);

    // R5
    strobe_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($past(stop_ev) && !$past(wr_stb)));

    // R8
    tx_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX) |-> cmd_valid);

    // R2
    skip_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP || state == ST_IDLE) |-> !sda_oe);
endmodule

// File: tb/smbw_word_slave_tb.sv
module smbw_word_slave_tb_top;
    localparam int Q = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_oe, wr_stb;
    logic [7:0]  wr_cmd;
    logic [15:0] wr_data;
    logic [15:0] h_cur = 16'h0, h_vlt = 16'h0, h_rln = 16'h0, h_vin = 16'h0;
    wire         bus_sda = m_sda & ~sda_oe;

    int checks = 0, errors = 0, stb_cnt = 0, r10_viol = 0;
    logic [7:0]  last_cmd;
    logic [15:0] last_data;
    logic        prev_scl = 1'b1, prev_oe = 1'b0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    smbw_word_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
        .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_cmd(wr_cmd), .wr_data(wr_data),
        .rd_cur_i(h_cur), .rd_vlt_i(h_vlt), .rd_rln_i(h_rln), .rd_vin_i(h_vin)
    );

    always @(negedge clk) begin
        if (wr_stb) begin
            stb_cnt   <= stb_cnt + 1;
            last_cmd  <= wr_cmd;
            last_data <= wr_data;
        end
        if (rst_n && m_scl && prev_scl && (sda_oe != prev_oe)) r10_viol <= r10_viol + 1;
        prev_scl <= m_scl;
        prev_oe  <= sda_oe;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] cmd_of(input int idx);
        case (idx)
            0: return 8'h14;
            1: return 8'h15;
            2: return 8'h3D;
            default: return 8'h3E;
        endcase
    endfunction

    function automatic logic [15:0] exp_val(input logic [7:0] c);
        case (c)
            8'h14: return h_cur;
            8'h15: return h_vlt;
            8'h3D: return h_rln;
            default: return h_vin;
        endcase
    endfunction

    task automatic bus_start();
        tick(Q); m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(4*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            tick(Q); m_sda = b[i]; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        tick(Q); m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); acked = ~bus_sda; tick(Q); m_scl = 1'b0;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            tick(Q); m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); d[i] = bus_sda; tick(Q); m_scl = 1'b0;
        end
        tick(Q); m_sda = ~mack; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0;
    endtask

    task automatic write_word(input logic [6:0] a, input logic [7:0] c, input logic [15:0] d,
                              output logic [3:0] acks);
        bus_start();
        send_byte({a, 1'b0}, acks[3]);
        send_byte(c, acks[2]);
        send_byte(d[7:0], acks[1]);
        send_byte(d[15:8], acks[0]);
        bus_stop();
    endtask

    task automatic read_word(input logic [7:0] c, output logic [2:0] acks, output logic [15:0] d);
        bus_start();
        send_byte(8'h12, acks[2]);
        send_byte(c, acks[1]);
        bus_start();
        send_byte(8'h13, acks[0]);
        recv_byte(1'b1, d[7:0]);
        recv_byte(1'b0, d[15:8]);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0]  wa;
        logic [2:0]  ra;
        logic [15:0] rd, wd;
        logic [7:0]  c, b;
        int          s0;
        bit          ak;
        void'($urandom(32'd4242));

        tick(5);
        // R11: reset state
        chk(sda_oe == 1'b0, "R11 sda_oe", 32'(sda_oe), 0);
        chk(wr_stb == 1'b0, "R11 wr_stb", 32'(wr_stb), 0);
        rst_n = 1'b1;
        tick(10);

        // R4 R5 R3: directed write to every supported command
        for (int k = 0; k < 4; k++) begin
            s0 = stb_cnt;
            wd = 16'hA50F + 16'(k * 16'h1111);
            write_word(7'b0001001, cmd_of(k), wd, wa);
            chk(wa == 4'b1111, "R4 write acks", 32'(wa), 32'hF);
            chk(stb_cnt == s0 + 1, "R5 single strobe", 32'(stb_cnt - s0), 1);
            chk(last_cmd == cmd_of(k), "R3 wr_cmd", 32'(last_cmd), 32'(cmd_of(k)));
            chk(last_data == wd, "R4 wr_data", 32'(last_data), 32'(wd));
        end

        // R2: wrong address
        s0 = stb_cnt;
        write_word(7'b0001010, 8'h14, 16'h1234, wa);
        chk(wa == 4'b0000, "R2 wrong address not acked", 32'(wa), 0);
        chk(stb_cnt == s0, "R2 no strobe", 32'(stb_cnt - s0), 0);

        // R3: unsupported command
        s0 = stb_cnt;
        write_word(7'b0001001, 8'h16, 16'hBEEF, wa);
        chk(wa == 4'b1000, "R3 unsupported cmd acks", 32'(wa), 32'h8);
        chk(stb_cnt == s0, "R3 no strobe", 32'(stb_cnt - s0), 0);

        // R5: START in place of the committing STOP
        s0 = stb_cnt;
        bus_start();
        send_byte(8'h12, ak); send_byte(8'h15, ak); send_byte(8'h34, ak); send_byte(8'h12, ak);
        bus_start();
        send_byte(8'h20, ak);
        bus_stop();
        chk(stb_cnt == s0, "R5 start aborts commit", 32'(stb_cnt - s0), 0);

        // R1: STOP inside address byte, then a good write
        bus_start(); send_bits(8'h12, 4); bus_stop();
        s0 = stb_cnt;
        write_word(7'b0001001, 8'h3E, 16'h0F0F, wa);
        chk(wa == 4'b1111 && stb_cnt == s0 + 1 && last_data == 16'h0F0F,
            "R1 recover after mid-byte stop", 32'(last_data), 32'h0F0F);

        // R1: START inside a data byte restarts address reception
        s0 = stb_cnt;
        bus_start();
        send_byte(8'h12, ak); send_byte(8'h14, ak); send_bits(8'hFF, 3);
        bus_start();
        send_byte(8'h12, wa[3]); send_byte(8'h15, wa[2]); send_byte(8'hC3, wa[1]); send_byte(8'h5A, wa[0]);
        bus_stop();
        chk(wa == 4'b1111 && stb_cnt == s0 + 1 && last_cmd == 8'h15 && last_data == 16'h5AC3,
            "R1 mid-byte start", 32'(last_data), 32'h5AC3);

        // R8: read without a command
        bus_start(); send_byte(8'h13, ak); bus_stop();
        chk(ak == 1'b0, "R8 read without command", 32'(ak), 0);

        // R6: directed reads of every register
        h_cur = 16'h8001; h_vlt = 16'h7E42; h_rln = 16'h00FF; h_vin = 16'hFF00;
        for (int k = 0; k < 4; k++) begin
            read_word(cmd_of(k), ra, rd);
            chk(ra == 3'b111, "R6 read acks", 32'(ra), 7);
            chk(rd == exp_val(cmd_of(k)), "R6 read value", 32'(rd), 32'(exp_val(cmd_of(k))));
        end

        // R7: register input changes after the read acknowledge
        h_vlt = 16'h1357;
        bus_start(); send_byte(8'h12, ak); send_byte(8'h15, ak); bus_start(); send_byte(8'h13, ak);
        h_vlt = 16'hFFFF;
        recv_byte(1'b1, rd[7:0]); recv_byte(1'b0, rd[15:8]); bus_stop();
        chk(rd == 16'h1357, "R7 captured at ack", 32'(rd), 32'h1357);

        // R9: master NACK on the low byte
        h_rln = 16'h0000;
        bus_start(); send_byte(8'h12, ak); send_byte(8'h3D, ak); bus_start(); send_byte(8'h13, ak);
        recv_byte(1'b0, rd[7:0]); recv_byte(1'b0, rd[15:8]); bus_stop();
        chk(rd == 16'hFF00, "R9 released after NACK", 32'(rd), 32'hFF00);

        // Random mix of writes and reads
        for (int n = 0; n < 16; n++) begin
            c = cmd_of(int'($urandom % 4));
            wd = 16'($urandom);
            if ($urandom % 2 == 0) begin
                s0 = stb_cnt;
                write_word(7'b0001001, c, wd, wa);
                chk(wa == 4'b1111 && stb_cnt == s0 + 1 && last_cmd == c,
                    "R5 random write strobe", 32'(last_cmd), 32'(c));
                chk(last_data == wd, "R4 random write data", 32'(last_data), 32'(wd));
            end else begin
                h_cur = 16'($urandom); h_vlt = 16'($urandom);
                h_rln = 16'($urandom); h_vin = 16'($urandom);
                read_word(c, ra, rd);
                chk(ra == 3'b111 && rd == exp_val(c), "R6 random read", 32'(rd), 32'(exp_val(c)));
            end
        end
        b = 8'h00;

        // R10: SDA enable never moved while SCL high
        chk(r10_viol == 0, "R10 sda change while scl high", 32'(r10_viol), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule